// File: doc/BRIEF.md
# Multi-format PCM serial audio receiver

This block takes stereo PCM audio from a three-wire serial link (a bit clock, a word clock and one data line) and hands it to the rest of the chip as parallel left and right samples in the system clock domain. All three link signals are sampled by the system clock. A bit-clock rising edge is recognised inside the block, and the data bit and the word-clock level are taken at that edge. The block accepts I2S, left-justified and right-justified framing, selected by `fmt`. It accepts word lengths of 16, 20 or 24 bits, selected by `wlen`. Shorter words are sign-extended to the full output width.

A left/right pair is presented once per frame with a one-cycle `sample_valid` pulse, after the right word has arrived. The block also watches where each frame starts, measured in system clock cycles. It reports `locked` only after the frame period has stayed steady for a set number of frames. When the period jumps by more than a tolerance, lock is dropped and the outputs are cleared at once. Pairs delivered while unlocked carry zero (bipolar zero) until lock is regained.

Top module: `pcm_serial_rx`

## Requirements
- R1: After reset, `left_out` and `right_out` are zero, and `sample_valid` and `locked` are low.
- R2: With `fmt` = 0 (codes 3 to 7 act the same), I2S framing applies. Word clock low carries the left word and high carries the right word. The MSB is taken on the second bit-clock rise after a word-clock change.
- R3: With `fmt` = 1, left-justified framing applies. Word clock high carries the left word and low carries the right word. The MSB is taken on the first bit-clock rise after a word-clock change.
- R4: With `fmt` = 2, right-justified framing applies, with the same channel polarity as R3. The LSB is the bit taken on the last bit-clock rise before the word-clock change that ends the word.
- R5: `wlen` = 1 selects 20-bit words and `wlen` = 2 selects 16-bit words; 0 and 3 select 24 bits. Words arrive MSB first in two's complement and are sign-extended to 24 bits on the outputs.
- R6: Bits in a half-frame outside the selected word positions do not affect the delivered samples.
- R7: Each complete frame yields exactly one single-cycle `sample_valid` pulse, on which both channels of that frame are presented together. The pulse follows the completion of the right word.
- R8: A frame start is a rising word-clock level seen at a bit-clock rise. The first frame start opens timing. The second frame start sets a reference period in system clocks. `locked` rises at the frame start that completes LOCK_FRAMES (default 2) consecutive periods within DRIFT_TOL (default 24) clocks of the reference.
- R9: A period that differs from the reference by more than DRIFT_TOL clocks drops `locked`, clears the outputs and replaces the reference. A frame still running past reference + DRIFT_TOL also drops lock. A shift within the tolerance keeps lock and data.
- R10: A pair delivered while not locked has both channels at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, sampled by `clk` |
| lrclk | input | 1 | Word clock selecting the channel |
| sdata | input | 1 | Serial audio data |
| fmt | input | 3 | Framing select: 0 I2S, 1 left-justified, 2 right-justified |
| wlen | input | 2 | Word length select: 0/3 24 bits, 1 20 bits, 2 16 bits |
| left_out | output | 24 | Left sample, sign-extended |
| right_out | output | 24 | Right sample, sign-extended |
| sample_valid | output | 1 | One-cycle strobe when a new pair is presented |
| locked | output | 1 | Frame timing steady; samples pass unmuted |

## Verification
The hardest case to reach from the ports is losing lock and then regaining it. After the stretched frame, the reference period has been replaced, so the next normal frame is also a mismatch, and only later frames count toward lock again. The stimulus first stretches one left half by five bit clocks, which is inside the tolerance. It then stretches a left half by eight bit clocks, which is outside it. The scoreboard expects zero pairs for exactly the three frames that follow and exact data from the fourth, and the port `locked` is checked between frames.

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx #(
  parameter int SW          = 24,
  parameter int CW          = 7,
  parameter int PW          = 16,
  parameter int LOCK_FRAMES = 2,
  parameter int DRIFT_TOL   = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  input  logic [2:0]    fmt,
  input  logic [1:0]    wlen,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out,
  output logic          sample_valid,
  output logic          locked
);
  localparam int MW = $clog2(LOCK_FRAMES + 1);

  logic          bclk_q, bclk_qq, lr_q, sd_q, lr_prev;
  logic [CW-1:0] cnt, idx, nbits, cap_idx;
  logic [SW-1:0] sh, shifted, raw, word, left_hold;
  logic [PW-1:0] per_cnt, ref_per, diff;
  logic          have_edge, have_ref;
  logic [MW-1:0] match_cnt;

  logic rise, trans, frame_edge, is_lj, is_rj, is_i2s;
  logic cap, cap_left, in_tol, overrun, drop, mute;

  assign rise       = bclk_q && !bclk_qq;
  assign trans      = lr_q != lr_prev;
  assign frame_edge = rise && lr_q && !lr_prev;

  assign is_lj  = fmt == 3'd1;
  assign is_rj  = fmt == 3'd2;
  assign is_i2s = !is_lj && !is_rj;

  assign nbits   = (wlen == 2'd1) ? CW'(SW - 4) :
                   (wlen == 2'd2) ? CW'(SW - 8) : CW'(SW);
  assign idx     = trans ? '0 : cnt + 1'b1;
  assign cap_idx = is_i2s ? nbits : nbits - 1'b1;
  assign cap     = rise && (is_rj ? trans : (idx == cap_idx));

  assign shifted  = {sh[SW-2:0], sd_q};
  assign raw      = is_rj ? sh : shifted;
  assign cap_left = (is_rj ? lr_prev : lr_q) ^ is_i2s;

  always_comb begin
    for (int i = 0; i < SW; i++)
      word[i] = (CW'(i) < nbits) ? raw[i] : raw[nbits - 1'b1];
  end

  assign diff    = (per_cnt > ref_per) ? per_cnt - ref_per : ref_per - per_cnt;
  assign in_tol  = diff <= PW'(DRIFT_TOL);
  assign overrun = have_ref && ({1'b0, per_cnt} > ({1'b0, ref_per} + (PW+1)'(DRIFT_TOL)));
  assign drop    = overrun || (frame_edge && have_ref && !in_tol);
  assign mute    = !locked || drop;

  // serial front end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      lr_q    <= 1'b1;
      sd_q    <= 1'b0;
      lr_prev <= 1'b1;
      cnt     <= '1;
      sh      <= '0;
    end else begin
      bclk_q  <= bclk;
      bclk_qq <= bclk_q;
      lr_q    <= lrclk;
      sd_q    <= sdata;
      if (rise) begin
        lr_prev <= lr_q;
        cnt     <= idx;
        sh      <= shifted;
      end
    end
  end

  // frame period tracking and lock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt   <= '0;
      ref_per   <= '0;
      have_edge <= 1'b0;
      have_ref  <= 1'b0;
      match_cnt <= '0;
      locked    <= 1'b0;
    end else begin
      if (frame_edge) per_cnt <= PW'(1);
      else if (per_cnt != '1) per_cnt <= per_cnt + 1'b1;

      if (drop) begin
        match_cnt <= '0;
        locked    <= 1'b0;
      end
      if (frame_edge) begin
        if (!have_edge) begin
          have_edge <= 1'b1;
        end else if (!have_ref) begin
          have_ref <= 1'b1;
          ref_per  <= per_cnt;
        end else if (in_tol) begin
          if (match_cnt < MW'(LOCK_FRAMES)) match_cnt <= match_cnt + 1'b1;
          if (match_cnt + 1'b1 >= MW'(LOCK_FRAMES)) locked <= 1'b1;
        end else begin
          ref_per <= per_cnt;
        end
      end
    end
  end

  // sample delivery
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_hold    <= '0;
      left_out     <= '0;
      right_out    <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (drop) begin
        left_out  <= '0;
        right_out <= '0;
      end
      if (cap) begin
        if (cap_left) begin
          left_hold <= word;
        end else begin
          sample_valid <= 1'b1;
          left_out     <= mute ? '0 : left_hold;
          right_out    <= mute ? '0 : word;
        end
      end
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_muted_pair_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> ($past(locked) || (left_out == '0 && right_out == '0)));

  assert_lock_at_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_edge));

  assert_hold_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && locked) |-> ($stable(left_out) && $stable(right_out)));

  assert_sign_ext16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && wlen == 2'd2) |-> (right_out[SW-1:SW-9] == {9{right_out[SW-9]}}));

  assert_sign_ext20_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && wlen == 2'd1) |-> (left_out[SW-1:SW-5] == {5{left_out[SW-5]}}));

  assert_drop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (left_out == '0 && right_out == '0));
endmodule

// File: tb/pcm_serial_rx_tb.sv
module pcm_serial_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        lrclk = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  wlen = 2'd0;
  logic [23:0] left_out, right_out;
  logic        sample_valid, locked;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [49:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pcm_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wlen(wlen), .left_out(left_out), .right_out(right_out),
    .sample_valid(sample_valid), .locked(locked)
  );

  task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] sx(input logic [23:0] w, input int n);
    logic [23:0] o;
    for (int i = 0; i < 24; i++) o[i] = (i < n) ? w[i] : w[n-1];
    return o;
  endfunction

  function automatic logic bit_at(input logic [23:0] w, input int n, input int h, input int i, input int f);
    if (f == 1) return (i < n) ? w[n-1-i] : 1'b1;
    if (f == 2) return (i >= h - n) ? w[h-1-i] : 1'b1;
    return (i >= 1 && i <= n) ? w[n-i] : 1'b1;
  endfunction

  task automatic send_bit(input logic lv, input logic d);
    @(negedge clk); bclk = 1'b0; lrclk = lv; sdata = d;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_half(input logic lv, input logic [23:0] w, input int n, input int h, input int f);
    for (int i = 0; i < h; i++) send_bit(lv, bit_at(w, n, h, i, f));
  endtask

  // mode: 1 exact, 2 zero expected
  task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int n, input int f,
                            input int mode, input int hl, input string tag);
    logic lv;
    lv = (f == 1 || f == 2) ? 1'b1 : 1'b0;
    exp_q.push_back({2'(mode), sx(l, n), sx(r, n)});
    tag_q.push_back(tag);
    send_half(lv, l, n, hl, f);
    send_half(!lv, r, n, 32, f);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bclk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain(input logic tail_lv);
    for (int i = 0; i < 4; i++) send_bit(tail_lv, 1'b1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R7 pairs outstanding", 48'(exp_q.size()), 48'd0);
  endtask

  always @(negedge clk) begin
    if (rst_n && sample_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected strobe", {left_out, right_out}, 48'd0);
      end else begin
        logic [49:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[49:48] == 2'd2)
          chk({left_out, right_out} == 48'd0, t, {left_out, right_out}, 48'd0);
        else
          chk({left_out, right_out} == e[47:0], t, {left_out, right_out}, e[47:0]);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        chk(1'b0, "watchdog", 48'(cycles), 48'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(left_out == 0 && right_out == 0, "R1 outputs", {left_out, right_out}, 48'd0);
    chk(!sample_valid && !locked, "R1 flags", 48'({sample_valid, locked}), 48'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // I2S, 24 bit
    fmt = 3'd0; wlen = 2'd0;
    for (int k = 0; k < 3; k++) send_frame(24'h111111, 24'h222222, 24, 0, 2, 32, "R10 warm-up I2S");
    chk(!locked, "R8 no early lock", 48'(locked), 48'd0);
    send_frame(24'h123456, 24'hABCDEF, 24, 0, 1, 32, "R2 I2S pair");
    chk(locked, "R8 lock after steady frames", 48'(locked), 48'd1);
    send_frame(24'h800000, 24'h7FFFFF, 24, 0, 1, 32, "R2 I2S extremes");
    send_frame(24'h000001, 24'hFFFFFF, 24, 0, 1, 32, "R6 I2S padding ones");
    send_frame(24'h5A5A5A, 24'hA5A5A5, 24, 0, 1, 37, "R9 tolerated shift");
    chk(locked, "R9 lock kept", 48'(locked), 48'd1);
    send_frame(24'h0F0F0F, 24'hF0F0F0, 24, 0, 2, 40, "R9 shift mutes");
    chk(!locked, "R9 lock dropped", 48'(locked), 48'd0);
    chk(left_out == 0 && right_out == 0, "R9 outputs cleared", {left_out, right_out}, 48'd0);
    send_frame(24'h333333, 24'h444444, 24, 0, 2, 32, "R10 relock 1");
    send_frame(24'h555555, 24'h666666, 24, 0, 2, 32, "R10 relock 2");
    send_frame(24'h777777, 24'h888888, 24, 0, 1, 32, "R8 relocked data");
    chk(locked, "R8 relocked", 48'(locked), 48'd1);
    drain(1'b0);

    // left-justified, 20 bit
    do_reset();
    fmt = 3'd1; wlen = 2'd1;
    for (int k = 0; k < 4; k++) send_frame(24'h0AAAAA, 24'h05555, 20, 1, 2, 32, "R10 warm-up LJ");
    send_frame(24'h80000, 24'h7FFFF, 20, 1, 1, 32, "R3 LJ extremes");
    send_frame(24'hF0F0F, 24'h12345, 20, 1, 1, 32, "R5 LJ 20-bit sign");
    send_frame(24'h00001, 24'hFFFFE, 20, 1, 1, 32, "R6 LJ padding ones");
    drain(1'b1);

    // right-justified, 16 bit
    do_reset();
    fmt = 3'd2; wlen = 2'd2;
    for (int k = 0; k < 4; k++) send_frame(24'h00AAAA, 24'h5555, 16, 2, 2, 32, "R10 warm-up RJ");
    send_frame(24'h8000, 24'h7FFF, 16, 2, 1, 32, "R4 RJ extremes");
    send_frame(24'h1234, 24'hFEDC, 16, 2, 1, 32, "R5 RJ 16-bit sign");
    send_frame(24'h0001, 24'hFFFF, 16, 2, 1, 32, "R6 RJ padding ones");
    drain(1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule